// File: doc/BRIEF.md
# Half-Band Low-Pass FIR Core

This block is a fixed-coefficient, linear-phase, 55-tap half-band low-pass FIR filter. It accepts one signed 12-bit sample on every rising clock edge and delivers a full-precision signed result on every clock. No valid strobe or enable exists: the pipeline always advances, and its latency is fixed. Rate conversion, rounding, saturation and output formatting belong to the stages that follow it.

In a half-band filter every tap at an even, nonzero distance from the centre is exactly zero, and the centre tap is one half. The core uses both facts. It folds each pair of mirrored taps into a single pre-added term before multiplying. It keeps only the 14 nonzero pairs plus the centre, so it has 15 constant multipliers instead of 55. A registered binary adder tree then sums the 15 products. Coefficients are integers scaled by 2^15, so an output value divided by 32768 gives the filtered value in input units. The result carries guard bits so that later stages can round and detect overflow.

The pipeline has no control flow and no state machine. A sample is captured into the delay line, folded, multiplied, summed over four tree levels and registered once more at the output. The first tap of an impulse response therefore appears seven clocks after capture, and the centre tap appears 34 clocks after capture. A synchronous reset clears the delay line and every pipeline register.

Top module: `hb_fir_core`

## Requirements
- R1: While `rst` is high at a rising edge, the delay line and pipeline clear, and `dout` reads 0. After release, `dout` stays 0 for the first 7 edges whatever `din` is, and no sample captured before the reset ever contributes to a later output.
- R2: Take a sample x captured at edge E, with the 54 preceding captures all zero. `dout` after edge E+7 equals -1·x, which is the outermost tap. x has not reached `dout` after edge E+6.
- R3: For such an isolated sample, `dout` after edge E+34 equals 16384·x, which is the centre tap (one half). No other point of the response has a larger magnitude.
- R4: The impulse response ends with -1·x after edge E+61, and `dout` is 0 from edge E+62 onwards while the input stays zero.
- R5: For every odd tap index k in 0..54 other than 27, the impulse response after edge E+7+k is exactly 0.
- R6: The response is symmetric: the value after edge E+7+k equals the value after edge E+61-k, for k in 0..26.
- R7: After edge n, `dout` equals the sum over k = 0..54 of h[k]·x(n-7-k), exactly, as a 33-bit two's-complement value. x(m) is the sample captured at edge m, and is 0 before the last reset. The coefficients are h[27]=16384 and h[k]=h[54-k]. For the even indices k = 0,2,...,26 the values are -1, 4, -14, 33, -66, 118, -199, 319, -495, 757, -1153, 1832, -3319, 10378. Every other h[k] is 0.
- R8: If the same value c is captured at 62 consecutive edges, `dout` then equals 32772·c, a DC gain of 32772/32768.
- R9: The result never wraps. Full-scale input patterns give the exact sum, and |`dout`| never exceeds 2048·53760 = 110100480.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; every register updates on its rising edge |
| rst | input | 1 | Synchronous active-high reset of delay line and pipeline |
| din | input | 12 | Signed input sample, captured every rising edge |
| dout | output | 33 | Signed full-precision filter result, coefficient scale 2^15 |

## Verification
The properties assume that reset is high from time zero, and that `din` carries a defined value at every edge once reset is released. They also assume that nothing outside the clock and reset disturbs the pipeline, so that the input history alone decides the output. The stimulus holds reset from the first edge and always drives defined samples. It inserts long zero stretches and long runs of one held value, so that the isolated-sample and DC-gain properties actually fire, and it mixes full-scale extremes into the seeded random traffic so that the range bound is approached.

// File: rtl/hb_fir_pkg.sv
package hb_fir_pkg;

    // Fixed filter geometry
    localparam int HB_TAPS      = 55;
    localparam int HB_MID       = (HB_TAPS - 1) / 2;
    localparam int HB_PAIRS     = (HB_MID + 1) / 2;
    localparam int HB_LANES     = HB_PAIRS + 1;
    localparam int HB_COEF_W    = 16;
    localparam int HB_TREE_LVLS = $clog2(HB_LANES);

    typedef logic signed [HB_COEF_W-1:0] hb_coef_t;

    // Lane l < HB_PAIRS multiplies taps 2l and HB_TAPS-1-2l; the last lane is the centre.
    function automatic hb_coef_t hb_lane_coef(input int lane);
        hb_coef_t c;
        case (lane)
            0:       c = -16'sd1;
            1:       c = 16'sd4;
            2:       c = -16'sd14;
            3:       c = 16'sd33;
            4:       c = -16'sd66;
            5:       c = 16'sd118;
            6:       c = -16'sd199;
            7:       c = 16'sd319;
            8:       c = -16'sd495;
            9:       c = 16'sd757;
            10:      c = -16'sd1153;
            11:      c = 16'sd1832;
            12:      c = -16'sd3319;
            13:      c = 16'sd10378;
            14:      c = 16'sd16384;
            default: c = '0;
        endcase
        return c;
    endfunction

    // Sum of all 55 taps, signed or by magnitude
    function automatic longint hb_coef_sum(input bit magnitude);
        longint acc;
        longint c;
        acc = 0;
        for (int l = 0; l < HB_LANES; l++) begin
            c = longint'(hb_lane_coef(l));
            if (magnitude && c < 0) c = -c;
            acc += (l == HB_PAIRS) ? c : 2 * c;
        end
        return acc;
    endfunction

endpackage

// File: rtl/hb_tap_line.sv
module hb_tap_line
    import hb_fir_pkg::*;
#(
    parameter int DATA_W = 12,
    parameter int DEPTH  = HB_TAPS
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic signed [DATA_W-1:0] din,
    output logic signed [DATA_W-1:0] taps [DEPTH]
);

    // taps[j] holds the sample captured j edges ago
    always_ff @(posedge clk) begin
        if (rst) begin
            for (int j = 0; j < DEPTH; j++) taps[j] <= '0;
        end else begin
            taps[0] <= din;
            for (int j = 1; j < DEPTH; j++) taps[j] <= taps[j-1];
        end
    end

endmodule

// File: rtl/hb_fold_mult.sv
module hb_fold_mult
    import hb_fir_pkg::*;
#(
    parameter int DATA_W = 12,
    parameter int ACC_W  = 33
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic signed [DATA_W-1:0] taps   [HB_TAPS],
    output logic signed [ACC_W-1:0]  prod_q [HB_LANES]
);

    localparam int SUM_W  = DATA_W + 1;
    localparam int PROD_W = SUM_W + HB_COEF_W;

    genvar ln;
    generate
        for (ln = 0; ln < HB_LANES; ln++) begin : g_lane
            localparam hb_coef_t LANE_C = hb_lane_coef(ln);
            logic signed [SUM_W-1:0] fold_w;
            logic signed [SUM_W-1:0] fold_q;

            if (ln < HB_PAIRS) begin : g_pair
                // mirrored taps share one coefficient
                assign fold_w = SUM_W'(taps[2*ln]) + SUM_W'(taps[HB_TAPS-1-2*ln]);
            end else begin : g_centre
                assign fold_w = SUM_W'(taps[HB_MID]);
            end

            always_ff @(posedge clk) begin
                if (rst) begin
                    fold_q     <= '0;
                    prod_q[ln] <= '0;
                end else begin
                    fold_q     <= fold_w;
                    prod_q[ln] <= ACC_W'(PROD_W'(fold_q) * PROD_W'(LANE_C));
                end
            end
        end
    endgenerate

endmodule

// File: rtl/hb_sum_tree.sv
module hb_sum_tree #(
    parameter int  ACC_W  = 33,
    parameter int  LEAVES = 15,
    localparam int LVLS   = $clog2(LEAVES),
    localparam int SPAN   = 1 << LVLS
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic signed [ACC_W-1:0] leaf_in [LEAVES],
    output logic signed [ACC_W-1:0] sum_q
);

    logic signed [ACC_W-1:0] leaf_w [SPAN];
    logic signed [ACC_W-1:0] node_q [1:SPAN-1];

    genvar gi, gn;
    generate
        for (gi = 0; gi < SPAN; gi++) begin : g_leaf
            if (gi < LEAVES) begin : g_used
                assign leaf_w[gi] = leaf_in[gi];
            end else begin : g_pad
                assign leaf_w[gi] = '0;
            end
        end

        // heap order: node n sums nodes 2n and 2n+1; one register per level
        for (gn = 1; gn < SPAN; gn++) begin : g_node
            logic signed [ACC_W-1:0] lhs;
            logic signed [ACC_W-1:0] rhs;
            if (2 * gn >= SPAN) begin : g_from_leaf
                assign lhs = leaf_w[2*gn-SPAN];
                assign rhs = leaf_w[2*gn+1-SPAN];
            end else begin : g_from_node
                assign lhs = node_q[2*gn];
                assign rhs = node_q[2*gn+1];
            end

            always_ff @(posedge clk) begin
                if (rst) node_q[gn] <= '0;
                else     node_q[gn] <= lhs + rhs;
            end
        end
    endgenerate

    assign sum_q = node_q[1];

endmodule

// File: rtl/hb_fir_core.sv
module hb_fir_core
    import hb_fir_pkg::*;
#(
    parameter int  DATA_W   = 12,
    parameter int  OUT_REGS = 1,
    localparam int ACC_W    = DATA_W + 1 + HB_COEF_W + HB_TREE_LVLS,
    localparam int LATENCY  = 2 + HB_TREE_LVLS + OUT_REGS
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic signed [DATA_W-1:0] din,
    output logic signed [ACC_W-1:0]  dout
);

    logic signed [DATA_W-1:0] taps   [HB_TAPS];
    logic signed [ACC_W-1:0]  prod_q [HB_LANES];
    logic signed [ACC_W-1:0]  root_q;

    hb_tap_line #(
        .DATA_W (DATA_W),
        .DEPTH  (HB_TAPS)
    ) tap_line_i (
        .clk  (clk),
        .rst  (rst),
        .din  (din),
        .taps (taps)
    );

    hb_fold_mult #(
        .DATA_W (DATA_W),
        .ACC_W  (ACC_W)
    ) fold_mult_i (
        .clk    (clk),
        .rst    (rst),
        .taps   (taps),
        .prod_q (prod_q)
    );

    hb_sum_tree #(
        .ACC_W  (ACC_W),
        .LEAVES (HB_LANES)
    ) sum_tree_i (
        .clk     (clk),
        .rst     (rst),
        .leaf_in (prod_q),
        .sum_q   (root_q)
    );

    // output alignment registers bring total latency to LATENCY
    generate
        if (OUT_REGS == 0) begin : g_no_align
            assign dout = root_q;
        end else begin : g_align
            logic signed [ACC_W-1:0] align_q [OUT_REGS];
            always_ff @(posedge clk) begin
                if (rst) begin
                    for (int s = 0; s < OUT_REGS; s++) align_q[s] <= '0;
                end else begin
                    align_q[0] <= root_q;
                    for (int s = 1; s < OUT_REGS; s++) align_q[s] <= align_q[s-1];
                end
            end
            assign dout = align_q[OUT_REGS-1];
        end
    endgenerate

endmodule

// File: rtl/hb_fir_core_chk.sv
module hb_fir_core_chk
    import hb_fir_pkg::*;
#(
    parameter int DATA_W = 12,
    parameter int ACC_W  = 33,
    parameter int LAT    = 7
) (
    input logic                     clk,
    input logic                     rst,
    input logic signed [DATA_W-1:0] din,
    input logic signed [ACC_W-1:0]  dout
);

    localparam int     WIN     = HB_TAPS + LAT;
    localparam int     CNT_W   = $clog2(WIN + 2) + 1;
    localparam longint DC_GAIN = hb_coef_sum(1'b0);
    localparam longint BOUND   = (longint'(1) << (DATA_W - 1)) * hb_coef_sum(1'b1);
    localparam longint H_EDGE  = longint'(hb_lane_coef(0));

    logic [CNT_W-1:0]         since_rst;
    logic [CNT_W-1:0]         zero_run;
    logic [CNT_W-1:0]         same_run;
    logic [CNT_W-1:0]         age;
    logic signed [DATA_W-1:0] last_din;
    logic signed [DATA_W-1:0] onset_val;

    always_ff @(posedge clk) begin
        if (rst) begin
            since_rst <= '0;
            zero_run  <= '1;
            same_run  <= '0;
            age       <= '0;
            last_din  <= '0;
            onset_val <= '0;
        end else begin
            since_rst <= (since_rst == '1) ? since_rst : since_rst + 1'b1;
            if (din == '0) zero_run <= (zero_run == '1) ? zero_run : zero_run + 1'b1;
            else           zero_run <= '0;
            if (din == last_din) same_run <= (same_run == '1) ? same_run : same_run + 1'b1;
            else                 same_run <= CNT_W'(1);
            last_din <= din;
            if (din != '0 && zero_run >= CNT_W'(HB_TAPS - 1)) begin
                age       <= CNT_W'(1);
                onset_val <= din;
            end else if (age != '0 && age != '1) begin
                age <= age + 1'b1;
            end
        end
    end

    AST_RESET_QUIET: assert property (@(posedge clk) disable iff (rst)
        (since_rst <= CNT_W'(LAT)) |-> (dout == '0)); // R1

    AST_ONSET_TAP: assert property (@(posedge clk) disable iff (rst)
        (age == CNT_W'(LAT + 1)) |-> (longint'(dout) == longint'(onset_val) * H_EDGE)); // R2

    AST_DC_GAIN: assert property (@(posedge clk) disable iff (rst)
        (same_run >= CNT_W'(WIN)) |-> (longint'(dout) == longint'(last_din) * DC_GAIN)); // R8

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        (longint'(dout) <= BOUND) && (longint'(dout) >= -BOUND)); // R9

endmodule

bind hb_fir_core hb_fir_core_chk #(
    .DATA_W (DATA_W),
    .ACC_W  (ACC_W),
    .LAT    (LATENCY)
) chk_i (
    .clk  (clk),
    .rst  (rst),
    .din  (din),
    .dout (dout)
);

// File: tb/hb_fir_core_tb_top.sv
`timescale 1ns/1ps
module hb_fir_core_tb_top;

    localparam int DW = 12;
    localparam int AW = 33;

    logic                 clk = 1'b0;
    logic                 rst = 1'b1;
    logic signed [DW-1:0] din = '0;
    logic signed [AW-1:0] dout;

    int     checks = 0;
    int     errors = 0;
    bit     done   = 0;
    longint hist [128];
    int     e      = 0;

    hb_fir_core dut_i (
        .clk  (clk),
        .rst  (rst),
        .din  (din),
        .dout (dout)
    );

    always #2 clk = ~clk;

    // tap values of R7, written by distance from the centre
    function automatic longint hcoef(input int k);
        int d;
        d = (k > 27) ? k - 27 : 27 - k;
        if (d == 0) return 16384;
        case (d)
            1: return 10378;   3: return -3319;  5: return 1832;
            7: return -1153;   9: return 757;    11: return -495;
            13: return 319;    15: return -199;  17: return 118;
            19: return -66;    21: return 33;    23: return -14;
            25: return 4;      27: return -1;
            default: return 0;
        endcase
    endfunction

    function automatic longint model(input int n);
        longint s;
        s = 0;
        for (int k = 0; k < 55; k++) begin
            if (n - 7 - k >= 0) s += hcoef(k) * hist[(n - 7 - k) % 128];
        end
        return s;
    endfunction

    task automatic check(input string req, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: got %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic finish_run();
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    // drive at negedge, capture at posedge, compare at next negedge (R7; R1 while e<7)
    task automatic step(input longint v, output longint got);
        din = v[DW-1:0];
        @(posedge clk);
        hist[e % 128] = v;
        @(negedge clk);
        got = longint'(dout);
        check((e < 7) ? "R1 warm-up" : "R7 convolution", got, model(e));
        e++;
    endtask

    task automatic do_reset(input int n);
        din = '0;
        rst = 1'b1;
        repeat (n) @(posedge clk);
        @(negedge clk);
        check("R1 in reset", longint'(dout), 0);
        rst = 1'b0;
        e   = 0;
        for (int i = 0; i < 128; i++) hist[i] = 0;
    endtask

    task automatic zeros(input int n);
        longint g;
        for (int i = 0; i < n; i++) step(0, g);
    endtask

    task automatic impulse(input longint amp);
        longint r [71];
        longint pk;
        zeros(60);
        step(amp, r[0]);
        for (int j = 1; j < 71; j++) step(0, r[j]);
        check("R2 before first tap", r[6], 0);
        check("R2 first tap", r[7], -amp);
        check("R3 centre peak", r[34], 16384 * amp);
        pk = (r[34] < 0) ? -r[34] : r[34];
        for (int j = 0; j < 71; j++) begin
            if (j != 34) check("R3 peak largest", ((r[j] < 0 ? -r[j] : r[j]) < pk) ? 1 : 0, 1);
        end
        check("R4 last tap", r[61], -amp);
        for (int j = 62; j < 71; j++) check("R4 tail zero", r[j], 0);
        for (int k = 1; k < 55; k += 2) begin
            if (k != 27) check("R5 zero tap", r[7 + k], 0);
        end
        for (int k = 0; k < 27; k++) check("R6 symmetry", r[7 + k], r[61 - k]);
    endtask

    task automatic hold_dc(input longint c);
        longint g;
        for (int i = 0; i < 80; i++) step(c, g);
        check("R8 dc gain", g, 32772 * c);
    endtask

    // drive the sign pattern of the taps at full scale, polarity pol
    task automatic worst_case(input bit pol);
        longint g, expv, v, h;
        zeros(60);
        expv = 0;
        for (int k = 54; k >= 0; k--) begin
            h = hcoef(k);
            if (h == 0) v = 0;
            else if ((h > 0) ^ pol) v = 2047;
            else v = -2048;
            expv += h * v;
            step(v, g);
        end
        for (int i = 0; i < 7; i++) step(0, g);
        check("R9 full-scale sum", g, expv);
        check("R9 within bound", ((g <= 110100480) && (g >= -110100480)) ? 1 : 0, 1);
    endtask

    task automatic random_run(input int n);
        longint g, v;
        logic signed [DW-1:0] t;
        int sel;
        for (int i = 0; i < n; i++) begin
            sel = int'($urandom % 8);
            t   = DW'($urandom);
            case (sel)
                0: v = 2047;
                1: v = -2048;
                2: v = 0;
                default: v = longint'(t);
            endcase
            step(v, g);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL R7 watchdog: got timeout expected completion");
            finish_run();
        end
    end

    initial begin
        longint g;
        void'($urandom(32'd20240611));
        @(negedge clk);
        do_reset(4);                 // R1
        impulse(1000);               // R2..R6
        impulse(-2048);              // R3 with full-scale negative sample
        hold_dc(2047);               // R8
        hold_dc(-2048);              // R8
        hold_dc(0);
        worst_case(1'b0);            // R9
        worst_case(1'b1);            // R9
        random_run(2000);            // R7
        do_reset(2);                 // R1: old history must vanish
        random_run(7);
        random_run(300);
        hold_dc(-777);               // R8
        step(0, g);
        finish_run();
    end

endmodule